// File: doc/BRIEF.md
# CCK Largest Correlation Picker

This block turns one symbol's worth of complementary-code correlator outputs into data nibbles. A correlator bank, outside the block, presents a signed value for every candidate code word on both the in-phase and quadrature channels at once, qualified by a one-cycle strobe. The picker finds the candidate with the greatest absolute value across both channels. It keeps the index of that candidate and notes which channel won. It then forms a quadrant phase from the channel and the sign of the winning value. This phase is decoded differentially against a running reference.

The running reference is seeded from the last demodulated header bit before the payload starts. From then on it follows the absolute phase of each decided symbol. In the low-rate mode only the first four candidates per channel take part, and each symbol gives one nibble. In the high-rate mode all sixty-four candidates take part, and each symbol gives two nibbles on consecutive cycles. The nibbles go on, in order, to a serializer and descrambler.

Top module: `cck_picker`

## Requirements
- R1: The winner is the candidate with the largest absolute value, taken over both channels. The most negative input value has magnitude 2^(CW-1) and so beats every positive value.
- R2: On equal magnitudes the lowest candidate index wins. At the same index an in-phase candidate beats a quadrature one.
- R3: The absolute phase code is 0 for a positive in-phase winner, 1 for a positive quadrature winner, 2 for a negative in-phase winner and 3 for a negative quadrature winner. The decoded phase pair is (absolute − reference) mod 4.
- R4: A cycle with `hdr_load` high sets the reference to 0 when `hdr_bit` is 0 and to 2 when it is 1. A load takes priority over a symbol update in the same cycle.
- R5: After each symbol the reference becomes that symbol's absolute phase code.
- R6: In low-rate mode (`hi_rate` low with the strobe) exactly one nibble is emitted: bits [3:2] hold the phase pair and bits [1:0] hold the winning index.
- R7: In high-rate mode two nibbles are emitted on consecutive cycles. The first is index bits [3:0]. The second holds the phase pair in bits [3:2] and index bits [5:4] in bits [1:0].
- R8: The first nibble of a symbol is valid in the second cycle after the strobe. `nib_vld` is high for exactly one cycle per nibble and low at all other times. Low-rate symbols may arrive on back-to-back cycles.
- R9: Reset clears `nib_vld` and sets the reference to 0.
- R10: In low-rate mode, candidates with index 4 or above have no effect on the output, whatever their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe marking a symbol's correlator outputs |
| hi_rate | input | 1 | Rate mode, sampled with the strobe: 1 = 64 candidates and 2 nibbles |
| hdr_load | input | 1 | Loads the phase reference from `hdr_bit` |
| hdr_bit | input | 1 | Last demodulated header bit |
| corr_i | input | NC_HI*CW | In-phase correlations; candidate k occupies bits [k*CW +: CW] |
| corr_q | input | NC_HI*CW | Quadrature correlations, packed the same way |
| nib_vld | output | 1 | Nibble valid pulse |
| nib_data | output | 4 | Decoded nibble |

## Verification
The bench sets up exact ties, both within one channel at different indices and between the two channels at the same index. A picker with the wrong preference would output the wrong index or the wrong quadrant. It also places the most negative value against the largest positive one. A magnitude stage that wraps would then choose the positive candidate. In low-rate symbols it puts dominant values above index 3; a block that fails to mask them would report an index it should never see. Long runs of random symbols, with mixed modes and reference reloads in between, expose a reference that fails to chain, a swapped nibble order, and timing slips on back-to-back low-rate symbols.

// File: rtl/cck_pkg.sv
package cck_pkg;

    typedef logic [1:0] phase_t;

    // Quadrant codes: bit 1 is the sign, bit 0 the channel
    localparam phase_t PH_POS_I = 2'd0;
    localparam phase_t PH_NEG_I = 2'd2;

    function automatic phase_t header_phase(input logic bit_v);
        return bit_v ? PH_NEG_I : PH_POS_I;
    endfunction

endpackage

// File: rtl/cck_mag_bank.sv
module cck_mag_bank #(
    parameter int CW    = 12,
    parameter int NC_HI = 64,
    parameter int NC_LO = 4
) (
    input  logic [NC_HI*CW-1:0] corr_i,
    input  logic [NC_HI*CW-1:0] corr_q,
    input  logic                hi_rate,
    output logic [CW-1:0]       mag_o [2*NC_HI],
    output logic [2*NC_HI-1:0]  neg_o
);
    // Leaf order is I0, Q0, I1, Q1, ... so that a lower leaf number gives priority
    for (genvar k = 0; k < NC_HI; k++) begin : g_cand
        logic [CW-1:0] vi, vq;
        logic          act;
        assign vi  = corr_i[k*CW +: CW];
        assign vq  = corr_q[k*CW +: CW];
        assign act = hi_rate || (k < NC_LO);

        assign mag_o[2*k]   = !act ? '0 : (vi[CW-1] ? (~vi + 1'b1) : vi);
        assign mag_o[2*k+1] = !act ? '0 : (vq[CW-1] ? (~vq + 1'b1) : vq);
        assign neg_o[2*k]   = vi[CW-1];
        assign neg_o[2*k+1] = vq[CW-1];
    end

endmodule

// File: rtl/cck_max_tree.sv
module cck_max_tree #(
    parameter int MW = 12,
    parameter int N  = 128,
    localparam int LV = $clog2(N),
    localparam int IW = (LV < 1) ? 1 : LV
) (
    input  logic [MW-1:0] mag_i [N],
    output logic [IW-1:0] win_o
);
    // Balanced tree, level l holds N>>l nodes; the right child wins only on strict greater
    for (genvar l = 0; l <= LV; l++) begin : g_lv
        logic [MW-1:0] m  [N>>l];
        logic [IW-1:0] ix [N>>l];
        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < N; j++) begin : g_j
                assign m[j]  = mag_i[j];
                assign ix[j] = IW'(j);
            end
        end else begin : g_node
            for (genvar j = 0; j < (N>>l); j++) begin : g_j
                logic take_r;
                assign take_r = g_lv[l-1].m[2*j+1] > g_lv[l-1].m[2*j];
                assign m[j]   = take_r ? g_lv[l-1].m[2*j+1]  : g_lv[l-1].m[2*j];
                assign ix[j]  = take_r ? g_lv[l-1].ix[2*j+1] : g_lv[l-1].ix[2*j];
            end
        end
    end

    assign win_o = g_lv[LV].ix[0];

endmodule

// File: rtl/cck_phase_diff.sv
module cck_phase_diff
    import cck_pkg::*;
(
    input  phase_t ref_i,
    input  logic   is_q,
    input  logic   neg,
    output phase_t abs_o,
    output phase_t dphi_o
);
    assign abs_o  = {neg, is_q};
    assign dphi_o = abs_o - ref_i;

endmodule

// File: rtl/cck_picker.sv
module cck_picker
    import cck_pkg::*;
#(
    parameter int CW    = 12,
    parameter int NC_HI = 64,
    parameter int NC_LO = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                hi_rate,
    input  logic                hdr_load,
    input  logic                hdr_bit,
    input  logic [NC_HI*CW-1:0] corr_i,
    input  logic [NC_HI*CW-1:0] corr_q,
    output logic                nib_vld,
    output logic [3:0]          nib_data
);
    localparam int NL   = 2 * NC_HI;
    localparam int LW   = $clog2(NL);
    localparam int IDXW = $clog2(NC_HI);
    localparam int LOW  = $clog2(NC_LO);

    typedef struct packed {
        logic            s1_vld;
        logic            s1_hi;
        logic [IDXW-1:0] s1_idx;
        logic            s1_q;
        logic            s1_neg;
        phase_t          ref_ph;
        logic            out_vld;
        logic [3:0]      out_nib;
        logic            pend_vld;
        logic [3:0]      pend_nib;
    } state_t;

    state_t q, d;

    logic [CW-1:0] mag   [NL];
    logic [NL-1:0] neg_v;
    logic [LW-1:0] win;
    phase_t        abs_ph, dphi;
    logic [7:0]    sym_byte;

    cck_mag_bank #(.CW(CW), .NC_HI(NC_HI), .NC_LO(NC_LO)) u_mag (
        .corr_i  (corr_i),
        .corr_q  (corr_q),
        .hi_rate (hi_rate),
        .mag_o   (mag),
        .neg_o   (neg_v)
    );

    cck_max_tree #(.MW(CW), .N(NL)) u_tree (
        .mag_i (mag),
        .win_o (win)
    );

    cck_phase_diff u_ph (
        .ref_i  (q.ref_ph),
        .is_q   (q.s1_q),
        .neg    (q.s1_neg),
        .abs_o  (abs_ph),
        .dphi_o (dphi)
    );

    assign sym_byte = {dphi, q.s1_idx};

    always_comb begin
        d = q;
        // Stage 1: search result captured with the strobe
        d.s1_vld = in_valid;
        if (in_valid) begin
            d.s1_hi  = hi_rate;
            d.s1_idx = win[LW-1:1];
            d.s1_q   = win[0];
            d.s1_neg = neg_v[win];
        end
        // Stage 2: differential decode and nibble sequencing
        d.out_vld = 1'b0;
        if (q.s1_vld) begin
            d.ref_ph  = abs_ph;
            d.out_vld = 1'b1;
            if (q.s1_hi) begin
                d.out_nib  = sym_byte[3:0];
                d.pend_vld = 1'b1;
                d.pend_nib = sym_byte[7:4];
            end else begin
                d.out_nib  = {dphi, q.s1_idx[LOW-1:0]};
                d.pend_vld = 1'b0;
            end
        end else if (q.pend_vld) begin
            d.out_vld  = 1'b1;
            d.out_nib  = q.pend_nib;
            d.pend_vld = 1'b0;
        end
        if (hdr_load) begin
            d.ref_ph = header_phase(hdr_bit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign nib_vld  = q.out_vld;
    assign nib_data = q.out_nib;

endmodule

// File: rtl/cck_picker_chk.sv
module cck_picker_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic hi_rate,
    input logic nib_vld
);
    AST_FIRST_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid, 2) |-> nib_vld);                                       // R8
    AST_SECOND_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(hi_rate, 2)) |=> nib_vld);                // R7
    AST_LOW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && !$past(hi_rate, 2) && !$past(in_valid)) |=> !nib_vld); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        nib_vld |-> ($past(in_valid, 2) || ($past(in_valid, 3) && $past(hi_rate, 3)))); // R8
    AST_VLD_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(nib_vld));                                                 // R9
endmodule

bind cck_picker cck_picker_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .hi_rate  (hi_rate),
    .nib_vld  (nib_vld)
);

// File: tb/tb_cck_picker.sv
module tb_cck_picker;
    localparam int CW = 12;
    localparam int NC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, hi_rate = 1'b0, hdr_load = 1'b0, hdr_bit = 1'b0;
    logic [NC*CW-1:0] corr_i = '0, corr_q = '0;
    logic nib_vld;
    logic [3:0] nib_data;

    always #4 clk = ~clk;   // 125 MHz

    cck_picker #(.CW(CW), .NC_HI(NC), .NC_LO(4)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hi_rate(hi_rate),
        .hdr_load(hdr_load), .hdr_bit(hdr_bit), .corr_i(corr_i), .corr_q(corr_q),
        .nib_vld(nib_vld), .nib_data(nib_data)
    );

    int compared = 0, mismatched = 0;
    int cyc = 0;
    bit done = 0;
    int ci [NC];
    int cq [NC];
    int model_ref = 0;
    int    exp_nib [int];
    string exp_tag [int];

    always @(posedge clk) cyc <= cyc + 1;

    // Reference comparison on every cycle after reset
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (exp_nib.exists(cyc)) begin
                if (!nib_vld || int'(nib_data) != exp_nib[cyc]) begin
                    mismatched++;
                    $display("FAIL %s cyc %0d: vld=%0b nib=%0d expected vld=1 nib=%0d",
                             exp_tag[cyc], cyc, nib_vld, nib_data, exp_nib[cyc]);
                end
                exp_nib.delete(cyc);
                exp_tag.delete(cyc);
            end else if (nib_vld !== 1'b0) begin
                mismatched++;
                $display("FAIL R8 cyc %0d: vld=%0b expected vld=0", cyc, nib_vld);
            end
        end
    end

    task automatic clear_corr();
        for (int k = 0; k < NC; k++) begin ci[k] = 0; cq[k] = 0; end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_hdr(bit b);
        idle(3);
        hdr_load = 1'b1; hdr_bit = b;
        model_ref = b ? 2 : 0;
        @(negedge clk);
        hdr_load = 1'b0;
    endtask

    // Drive one symbol at the current negedge and register its expected nibbles
    task automatic send(bit hi, string tag);
        int best, bk, bq, bneg, n, m, v, absph, dphi, e;
        best = -1; bk = 0; bq = 0; bneg = 0;
        n = hi ? NC : 4;
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < 2; c++) begin
                v = c ? cq[k] : ci[k];
                m = (v < 0) ? -v : v;
                if (m > best) begin best = m; bk = k; bq = c; bneg = (v < 0); end
            end
        end
        absph = bneg * 2 + bq;
        dphi = (absph - model_ref + 4) % 4;
        model_ref = absph;
        e = cyc + 1;
        if (hi) begin
            exp_nib[e + 1] = bk % 16;               exp_tag[e + 1] = tag;
            exp_nib[e + 2] = dphi * 4 + bk / 16;    exp_tag[e + 2] = tag;
        end else begin
            exp_nib[e + 1] = dphi * 4 + (bk % 4);   exp_tag[e + 1] = tag;
        end
        for (int k = 0; k < NC; k++) begin
            corr_i[k*CW +: CW] = CW'(ci[k]);
            corr_q[k*CW +: CW] = CW'(cq[k]);
        end
        hi_rate = hi;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (hi) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        clear_corr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: output quiet right after reset
        compared++;
        if (nib_vld !== 1'b0) begin
            mismatched++;
            $display("FAIL R9: vld=%0b expected 0", nib_vld);
        end
        // R9 / R6: reference starts at 0, low-rate nibble layout
        clear_corr(); ci[2] = 900;
        send(0, "R9");
        idle(2);
        // R3 quadrant codes, chaining per R5
        clear_corr(); cq[1] = 700;  send(0, "R3");
        clear_corr(); ci[3] = -800; send(0, "R3");
        clear_corr(); cq[0] = -650; send(0, "R5");
        idle(2);
        // R4: reload from header bit 1 and bit 0
        load_hdr(1'b1);
        clear_corr(); ci[1] = 300; send(0, "R4");
        load_hdr(1'b0);
        clear_corr(); cq[2] = -300; send(0, "R4");
        idle(2);
        // R2: ties across indices and across channels
        clear_corr(); ci[3] = 500; ci[1] = 500; send(0, "R2");
        clear_corr(); ci[2] = -500; cq[2] = 500; send(0, "R2");
        clear_corr(); cq[0] = 400; ci[1] = -400; send(0, "R2");
        clear_corr(); send(0, "R2");
        // R1: most negative value beats the largest positive
        clear_corr(); ci[0] = 2047; cq[3] = -2048; send(0, "R1");
        // R10: dominant candidates above index 3 ignored in low-rate
        clear_corr(); ci[40] = -2048; cq[9] = 2047; ci[2] = 10; send(0, "R10");
        // R7: high-rate, winner at high index
        clear_corr(); cq[50] = -1500; ci[20] = 1400; send(1, "R7");
        clear_corr(); ci[63] = 1000; cq[63] = -1000; send(1, "R7");
        clear_corr(); ci[17] = -2048; cq[5] = 2047; send(1, "R1");
        // R8: back-to-back low-rate followed by high-rate
        clear_corr(); ci[1] = 77; send(0, "R8");
        clear_corr(); cq[3] = -99; send(0, "R8");
        clear_corr(); cq[33] = 123; send(1, "R8");
        idle(3);
        // Random traffic with mixed modes, small values to force ties
        for (int t = 0; t < 400; t++) begin
            int span;
            bit hi;
            span = (t % 3 == 0) ? 3 : 2047;
            hi = ($urandom_range(1) == 1);
            for (int k = 0; k < NC; k++) begin
                ci[k] = int'($urandom_range(2 * span + 1)) - span - 1;
                cq[k] = int'($urandom_range(2 * span + 1)) - span - 1;
            end
            if (t % 50 == 49) load_hdr(($urandom_range(1) == 1));
            send(hi, hi ? "R7" : "R6");
            if ($urandom_range(3) == 0) idle(1);
        end
        idle(6);
        if (exp_nib.num() != 0) begin
            mismatched++;
            $display("FAIL R8: %0d nibbles never seen, expected 0", exp_nib.num());
        end
        finish_run();
    end

endmodule